// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identifier

This block gathers the interrupt sources of a UART running with receive and transmit FIFOs and reduces them to one identification code and one interrupt line. The sources are a receive line error, received data at or above a programmable trigger level, a receive-idle character timeout, a transmit FIFO data request and a modem status change. Each source is gated by a bit of an eight-bit enable register that the block holds itself. The highest-priority gated source is registered into a four-bit identification code. Bit 0 of that code is low while an interrupt is pending.

The character-timeout timer lives inside the block. It counts baud ticks while the receive FIFO holds data. Every received character and every FIFO read restart it. After four character times without either, it raises the timeout source. The character length, in baud ticks, is an input. The enable register also keeps the rule that DMA and programmed I/O must not serve the same FIFO: a write cannot leave the DMA enable set together with either FIFO interrupt enable.

Top module: `uart_irq_id`

## Requirements
- R1: During and right after reset the enable register reads 8'h00, the identification code reads 4'b0001 and the interrupt line is low.
- R2: A write stores the enable bits one edge after the write strobe. The layout is bit 0 receive-data enable, bit 1 transmit-request enable, bit 2 line-status enable, bit 3 modem enable, bit 4 receive-timeout enable, bit 5 line-coding flag (stored only), bit 6 unit enable and bit 7 DMA enable.
- R3: Bit 7 is stored as 1 only when the same write has both bit 1 and bit 0 at 0. Otherwise bit 7 stores 0 and the other bits are stored as written.
- R4: The code follows a fixed priority order, from highest to lowest: line status 4'b0110, then the receive level (data available 4'b0100, then timeout 4'b1100), then transmit request 4'b0010, then modem 4'b0000. With nothing pending the code is 4'b0001. The code is registered one edge after its inputs.
- R5: Data available means the receive level is at or above the threshold set by the 2-bit trigger select. For FIFO depth D, 2'b00 gives 1, 2'b01 gives D/8, 2'b10 gives D/4 and 2'b11 gives D/2.
- R6: While data available is enabled and active, the code is never 4'b1100, even when a timeout is pending.
- R7: The timeout becomes pending on the edge of the (4 x char_ticks)-th baud tick after the last restart. This requires a non-empty FIFO and no character received or read in that span. A char_ticks value of 0 disables the timer.
- R8: A received character or a FIFO read clears a pending timeout and restarts the count. An empty FIFO clears the timeout and holds the count at zero.
- R9: A source whose enable bit is 0 never shows in the code.
- R10: The interrupt line is high exactly when code bit 0 is 0 and the unit enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien_wr | input | 1 | Enable register write strobe |
| ien_wdata | input | 8 | Enable register write value |
| ien_rdata | output | 8 | Enable register contents |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | 2 | Receive trigger select |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_pop | input | 1 | The receive FIFO was read |
| line_err | input | 1 | Receive line error flag |
| tx_req | input | 1 | Transmit FIFO requests data |
| modem_chg | input | 1 | Modem status changed |
| baud_tick | input | 1 | One baud period elapsed |
| char_ticks | input | CHR_W | Baud ticks per character |
| iir | output | 4 | Identification code |
| irq | output | 1 | Interrupt line |

## Verification
The code and the interrupt line reflect inputs and enable bits one rising edge after those inputs are applied. An enable write shows on the readback one edge after the strobe. The timeout is set on the edge of its final baud tick, so it reaches the code one edge later. The bench applies inputs after a falling edge and advances its reference model across exactly one rising edge. It then compares all outputs at the next falling edge, so every check lands on the cycle in which the result is due.

// File: rtl/uirq_pkg.sv
// Shared types for the UART interrupt identifier.
// Assumes: enable register layout and code values are fixed by the system.
package uirq_pkg;

    // Enable register, bit 7 down to bit 0
    typedef struct packed {
        logic en_dma;    // bit 7: DMA service of the FIFOs
        logic en_unit;   // bit 6: unit enable, gates the interrupt line
        logic en_nrz;    // bit 5: line coding flag, stored only
        logic en_rxto;   // bit 4: receive timeout source
        logic en_modem;  // bit 3: modem status source
        logic en_lstat;  // bit 2: receive line status source
        logic en_txreq;  // bit 1: transmit request source
        logic en_rxdat;  // bit 0: receive data available source
    } ien_t;

    // Identification codes; bit 0 low means pending
    typedef enum logic [3:0] {
        ID_MODEM = 4'b0000,
        ID_NONE  = 4'b0001,
        ID_TXREQ = 4'b0010,
        ID_RXDAT = 4'b0100,
        ID_LSTAT = 4'b0110,
        ID_RXTO  = 4'b1100
    } iid_e;

endpackage

// File: rtl/uirq_ien_reg.sv
// Interrupt enable register.
// Holds the eight enable bits. On a write, the DMA enable is kept only
// when the written FIFO interrupt enables (bits 1 and 0) are both clear.
// Assumes: one write per strobe cycle; synchronous active-low reset.
module uirq_ien_reg
    import uirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output ien_t       ien
);

    ien_t wr_val;

    // Apply the DMA exclusion rule to the written value
    always_comb begin
        wr_val        = ien_t'(wr_data);
        wr_val.en_dma = wr_data[7] & ~wr_data[1] & ~wr_data[0];
    end

    // Register update on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= '0;
        end else if (wr_en) begin
            ien <= wr_val;
        end
    end

    // R3: DMA never stored together with a FIFO interrupt enable
    a_r3_dma_excl: assert property (@(posedge clk) disable iff (!rst_n)
        ien.en_dma |-> !(ien.en_txreq || ien.en_rxdat));

    // R2: register holds its value without a strobe
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ien));

endmodule

// File: rtl/uirq_rx_timer.sv
// Receive character-timeout timer.
// Counts baud ticks while the receive FIFO is non-empty. The timeout
// becomes pending after four character times with no character received
// and no FIFO read. A push or pop restarts the count. An empty FIFO clears
// the timer and holds it. A character time of zero disables the timer.
// Assumes: baud_tick is a one-cycle pulse.
module uirq_rx_timer #(
    parameter int LVL_W = 7,
    parameter int CHR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             baud_tick,
    input  logic [CHR_W-1:0] char_ticks,
    output logic             to_pend
);

    localparam int CNT_W = CHR_W + 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_inc;
    logic             rx_empty;
    logic             restart;

    // Derive the four-character limit and the control conditions
    always_comb begin
        limit    = {char_ticks, 2'b00};
        cnt_inc  = cnt + 1'b1;
        rx_empty = (rx_level == '0);
        restart  = rx_push | rx_pop;
    end

    // Idle counter and pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            to_pend <= 1'b0;
        end else if (rx_empty || restart) begin
            cnt     <= '0;
            to_pend <= 1'b0;
        end else if (baud_tick && (limit != '0) && !to_pend) begin
            cnt <= cnt_inc;
            if (cnt_inc == limit) begin
                to_pend <= 1'b1;
            end
        end
    end

    // R8: push or pop cancels a pending timeout at the next edge
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rx_pop) |=> !to_pend);

    // R8: empty FIFO halts the timer
    a_r8_empty_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |=> (!to_pend && cnt == '0));

    // R7: zero character time never raises a timeout
    a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (char_ticks == '0 && !to_pend) |=> !to_pend);

endmodule

// File: rtl/uirq_resolver.sv
// Priority resolver.
// Gates each source with its enable bit and picks the single highest
// pending code. Data available is checked before timeout within the
// receive level. Also decodes the data-available threshold.
// Assumes: DEPTH is a multiple of 8.
module uirq_resolver
    import uirq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input  ien_t             ien,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [1:0]       rx_trig,
    input  logic             line_err,
    input  logic             tx_req,
    input  logic             modem_chg,
    input  logic             to_pend,
    output logic             rx_avail,
    output iid_e             code
);

    localparam int NTRIG = 4;
    localparam logic [LVL_W-1:0] TH_MIN = LVL_W'(1);

    logic [LVL_W-1:0] thr_tab [NTRIG];
    logic [LVL_W-1:0] thr;

    // Threshold table: 1, then DEPTH/8, DEPTH/4 and DEPTH/2
    for (genvar g = 0; g < NTRIG; g++) begin : g_thr
        if (g == 0) begin : g_min
            assign thr_tab[g] = TH_MIN;
        end else begin : g_frac
            assign thr_tab[g] = LVL_W'(DEPTH >> (4 - g));
        end
    end

    // Select the threshold and compare the level
    always_comb begin
        thr      = thr_tab[rx_trig];
        rx_avail = (rx_level >= thr);
    end

    // Fixed-priority selection of the gated sources
    always_comb begin
        if (ien.en_lstat && line_err) begin
            code = ID_LSTAT;
        end else if (ien.en_rxdat && rx_avail) begin
            code = ID_RXDAT;
        end else if (ien.en_rxto && to_pend) begin
            code = ID_RXTO;
        end else if (ien.en_txreq && tx_req) begin
            code = ID_TXREQ;
        end else if (ien.en_modem && modem_chg) begin
            code = ID_MODEM;
        end else begin
            code = ID_NONE;
        end
    end

endmodule

// File: rtl/uart_irq_id.sv
// UART interrupt prioritizer and identifier, top level.
// Holds the enable register, runs the character-timeout timer, resolves
// the sources and registers the code. The interrupt line comes from the
// registered code and the unit enable.
// Assumes: all inputs are synchronous to clk.
module uart_irq_id
    import uirq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CHR_W = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_wr,
    input  logic [7:0]       ien_wdata,
    output logic [7:0]       ien_rdata,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [1:0]       rx_trig,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             line_err,
    input  logic             tx_req,
    input  logic             modem_chg,
    input  logic             baud_tick,
    input  logic [CHR_W-1:0] char_ticks,
    output logic [3:0]       iir,
    output logic             irq
);

    ien_t ien;
    logic to_pend;
    logic rx_avail;
    iid_e code_nxt;
    iid_e iir_q;

    uirq_ien_reg u_ien (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ien_wr),
        .wr_data (ien_wdata),
        .ien     (ien)
    );

    uirq_rx_timer #(.LVL_W(LVL_W), .CHR_W(CHR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_level   (rx_level),
        .rx_push    (rx_push),
        .rx_pop     (rx_pop),
        .baud_tick  (baud_tick),
        .char_ticks (char_ticks),
        .to_pend    (to_pend)
    );

    uirq_resolver #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_res (
        .ien       (ien),
        .rx_level  (rx_level),
        .rx_trig   (rx_trig),
        .line_err  (line_err),
        .tx_req    (tx_req),
        .modem_chg (modem_chg),
        .to_pend   (to_pend),
        .rx_avail  (rx_avail),
        .code      (code_nxt)
    );

    // Register the resolved code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iir_q <= ID_NONE;
        end else begin
            iir_q <= code_nxt;
        end
    end

    // Drive outputs from registered state
    always_comb begin
        ien_rdata = ien;
        iir       = iir_q;
        irq       = ~iir_q[0] & ien.en_unit;
    end

    // R4: only defined codes appear
    a_r4_legal: assert property (@(posedge clk) disable iff (!rst_n)
        iir_q inside {ID_NONE, ID_LSTAT, ID_RXDAT, ID_RXTO, ID_TXREQ, ID_MODEM});

    // R6: enabled data available blocks the timeout code
    a_r6_dat_over_to: assert property (@(posedge clk) disable iff (!rst_n)
        (ien.en_rxdat && rx_avail) |=> (iir_q != ID_RXTO));

    // R9: disabled timeout is never reported
    a_r9_to_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ien.en_rxto |=> (iir_q != ID_RXTO));

    // R9: disabled line status is never reported
    a_r9_ls_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ien.en_lstat |=> (iir_q != ID_LSTAT));

    // R10: interrupt line needs the unit enable and a pending code
    a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien.en_unit && !iir_q[0]));

endmodule

// File: tb/uart_irq_id_tb_top.sv
// Bench for uart_irq_id: directed corner cases plus seeded random traffic,
// checked against a cycle model built from the requirements.
module uart_irq_id_tb_top;

    localparam int DEPTH = 64;
    localparam int CHR_W = 8;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ien_wr = 1'b0;
    logic [7:0]       ien_wdata = '0;
    logic [7:0]       ien_rdata;
    logic [LVL_W-1:0] rx_level = '0;
    logic [1:0]       rx_trig = '0;
    logic             rx_push = 1'b0;
    logic             rx_pop = 1'b0;
    logic             line_err = 1'b0;
    logic             tx_req = 1'b0;
    logic             modem_chg = 1'b0;
    logic             baud_tick = 1'b0;
    logic [CHR_W-1:0] char_ticks = '0;
    logic [3:0]       iir;
    logic             irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // model state
    logic [7:0] m_ien = '0;
    logic [3:0] m_iir = 4'b0001;
    logic       m_to  = 1'b0;
    int         m_cnt = 0;

    always #2.5 clk = ~clk;

    uart_irq_id #(.DEPTH(DEPTH), .CHR_W(CHR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .ien_rdata(ien_rdata), .rx_level(rx_level), .rx_trig(rx_trig),
        .rx_push(rx_push), .rx_pop(rx_pop), .line_err(line_err),
        .tx_req(tx_req), .modem_chg(modem_chg), .baud_tick(baud_tick),
        .char_ticks(char_ticks), .iir(iir), .irq(irq)
    );

    function automatic int f_thr(input logic [1:0] t);
        case (t)
            2'b00:   return 1;
            2'b01:   return DEPTH / 8;
            2'b10:   return DEPTH / 4;
            default: return DEPTH / 2;
        endcase
    endfunction

    function automatic logic [7:0] f_wr(input logic [7:0] d);
        return {d[7] & ~d[1] & ~d[0], d[6:0]};
    endfunction

    function automatic logic [3:0] f_code(input logic [7:0] e, input logic to);
        if (e[2] && line_err)                           return 4'b0110;
        if (e[0] && (int'(rx_level) >= f_thr(rx_trig))) return 4'b0100;
        if (e[4] && to)                                 return 4'b1100;
        if (e[1] && tx_req)                             return 4'b0010;
        if (e[3] && modem_chg)                          return 4'b0000;
        return 4'b0001;
    endfunction

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got=%h exp=%h at cycle %0d", tag, what, got, exp, cyc);
        end
    endtask

    // one clock: model advances over the rising edge, outputs checked at falling edge
    task automatic step(input string tag);
        logic [7:0] n_ien;
        logic [3:0] n_iir;
        logic       n_to;
        int         n_cnt;
        int         lim;
        lim   = 4 * int'(char_ticks);
        n_iir = f_code(m_ien, m_to);
        n_ien = ien_wr ? f_wr(ien_wdata) : m_ien;
        n_to  = m_to;
        n_cnt = m_cnt;
        if (rx_level == '0 || rx_push || rx_pop) begin
            n_to = 1'b0; n_cnt = 0;
        end else if (baud_tick && lim != 0 && !m_to) begin
            n_cnt = m_cnt + 1;
            if (n_cnt == lim) n_to = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        m_ien = n_ien; m_iir = n_iir; m_to = n_to; m_cnt = n_cnt;
        chk(tag, "iir", int'(iir), int'(m_iir));
        chk(tag, "ien", int'(ien_rdata), int'(m_ien));
        chk((tag == "RND") ? "R10" : tag, "irq", int'(irq), int'(~m_iir[0] & m_ien[6]));
    endtask

    task automatic wr_ien(input logic [7:0] v, input string tag);
        ien_wr = 1'b1; ien_wdata = v;
        step(tag);
        ien_wr = 1'b0;
    endtask

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'b0100: return "R5";
            4'b1100: return "R7";
            4'b0001: return "R9";
            default: return "R4";
        endcase
    endfunction

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R1: reset values, checked while reset is held
        chk("R1", "ien", int'(ien_rdata), 0);
        chk("R1", "iir", int'(iir), 1);
        chk("R1", "irq", int'(irq), 0);
        rst_n = 1'b1;
        step("R1");

        // R2 / R3: enable register writes
        wr_ien(8'h55, "R2");
        wr_ien(8'h3C, "R2");
        wr_ien(8'hFF, "R3");
        chk("R3", "dma bit with fifo enables", int'(ien_rdata), 8'h7F);
        wr_ien(8'hC0, "R3");
        chk("R3", "dma bit alone", int'(ien_rdata), 8'hC0);
        wr_ien(8'h82, "R3");
        wr_ien(8'h81, "R3");
        step("R2");

        // R7: timeout after 4 character times, char_ticks = 2 -> 8 ticks
        wr_ien(8'h50, "R7");
        char_ticks = 8'd2; rx_trig = 2'b00; baud_tick = 1'b1;
        rx_level = LVL_W'(3);
        for (int i = 0; i < 10; i++) step("R7");
        chk("R7", "timeout code", int'(iir), 4'b1100);
        chk("R10", "irq on timeout", int'(irq), 1);
        // R8: push cancels, empty clears
        rx_push = 1'b1; step("R8"); rx_push = 1'b0;
        step("R8");
        chk("R8", "cancelled by push", int'(iir), 4'b0001);
        for (int i = 0; i < 9; i++) step("R8");
        rx_pop = 1'b1; step("R8"); rx_pop = 1'b0;
        step("R8");
        chk("R8", "cancelled by pop", int'(iir), 4'b0001);
        rx_level = '0;
        for (int i = 0; i < 12; i++) step("R8");
        chk("R8", "empty fifo no timeout", int'(iir), 4'b0001);
        // R7: zero char time never times out
        char_ticks = '0; rx_level = LVL_W'(2);
        for (int i = 0; i < 12; i++) step("R7");
        chk("R7", "zero length", int'(iir), 4'b0001);

        // R6: data available beats timeout
        char_ticks = 8'd1;
        wr_ien(8'h51, "R6");
        for (int i = 0; i < 8; i++) step("R6");
        chk("R6", "data over timeout", int'(iir), 4'b0100);

        // R5: threshold per trigger select
        rx_trig = 2'b01; rx_level = LVL_W'(DEPTH / 8 - 1); rx_push = 1'b1;
        step("R5"); step("R5");
        chk("R5", "below 1/8", int'(iir), 4'b0001);
        rx_level = LVL_W'(DEPTH / 8); step("R5"); step("R5");
        chk("R5", "at 1/8", int'(iir), 4'b0100);
        rx_trig = 2'b11; step("R5"); step("R5");
        chk("R5", "below 1/2", int'(iir), 4'b0001);
        rx_level = LVL_W'(DEPTH / 2); step("R5");
        rx_trig = 2'b10; rx_level = LVL_W'(DEPTH / 4); step("R5");
        rx_push = 1'b0;

        // R4: priority ladder
        wr_ien(8'h4F, "R4");
        line_err = 1'b1; tx_req = 1'b1; modem_chg = 1'b1; step("R4");
        chk("R4", "line status top", int'(iir), 4'b0110);
        line_err = 1'b0; step("R4");
        chk("R4", "data next", int'(iir), 4'b0100);
        rx_level = '0; step("R4");
        chk("R4", "tx next", int'(iir), 4'b0010);
        tx_req = 1'b0; step("R4");
        chk("R4", "modem last", int'(iir), 4'b0000);
        // R9 / R10: all sources gated off, unit off
        wr_ien(8'h00, "R9");
        line_err = 1'b1; tx_req = 1'b1; step("R9");
        chk("R9", "all gated", int'(iir), 4'b0001);
        wr_ien(8'h08, "R10"); step("R10");
        chk("R10", "unit off no irq", int'(irq), 0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 0) char_ticks = CHR_W'($urandom_range(1, 3));
            ien_wr    = ($urandom_range(0, 19) == 0);
            ien_wdata = 8'($urandom());
            rx_level  = LVL_W'($urandom_range(0, 40));
            if ($urandom_range(0, 3) != 0) rx_level = LVL_W'($urandom_range(0, 2));
            rx_trig   = 2'($urandom());
            rx_push   = ($urandom_range(0, 39) == 0);
            rx_pop    = ($urandom_range(0, 39) == 0);
            line_err  = ($urandom_range(0, 9) == 0);
            tx_req    = ($urandom_range(0, 3) == 0);
            modem_chg = ($urandom_range(0, 7) == 0);
            baud_tick = ($urandom_range(0, 1) == 0);
            step("RND");
            if (n_bad != 0 && i < 2) $display("note: %s", tag_of(m_iir));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule